// File: doc/BRIEF.md
# Cache Maintenance Operation Unit

This unit carries out explicit maintenance commands on the tag and data arrays of a two-way, set-associative data cache. The cache has 64 sets and 64-byte lines. A command is a 5-bit operation code plus an effective address. The set always comes from address bits [11:6].

Commands fall into two families. Hit-type commands compare the address page against both tags of the set to find the way. Index-type commands take the way straight from address bit 0. Some commands invalidate or clean a line, and a line holding valid or dirty state is first pushed out over a 128-bit memory port in four consecutive beats. Other commands move a whole tag word, or a single 32-bit data word, between the arrays and a 32-bit transfer register that software can write at any time and read on `xferOut`.

Each tag word holds the page in bits [31:12], dirty in bit 6, valid in bit 5 and a replacement bit in bit 4. Clearing a line removes bits 6, 5 and 3:0 (mask 0x6F) and leaves the page, bit 4 and bits 11:7 untouched.

Top module: `cache_op_unit`

## Requirements
- R1: The set index is address bits [11:6]. Index-type commands (codes 0x10 to 0x16) select way 0 or 1 with address bit 0. Tags held in different sets or ways never alias.
- R2: Code 0x10 copies the selected 32-bit tag word into the transfer register. Code 0x12 writes the transfer register into that tag word. After reset every tag word and the transfer register read as zero.
- R3: Code 0x11 loads the data word selected by address bits [5:2] into the transfer register, and code 0x13 stores the register there. Bit 0 selects the way. If address bit 1 is set, neither command changes anything.
- R4: Code 0x1A (hit invalidate) acts only when the tag page equals address bits [31:12] and the valid bit is set. On such a hit it clears tag bits 0x6F and zeroes all 64 line bytes. When both ways hit, way 0 is taken. A miss changes nothing.
- R5: Code 0x18 (hit writeback-invalidate) writes a hit line back when tag bits 0x60 are non-zero, to line base {addr[31:6],6'b0}. It then clears bits 0x6F and zeroes the line.
- R6: Code 0x1C (hit writeback) writes a hit line back under the same rule. Afterwards it clears only bit 6 and keeps the data.
- R7: Code 0x16 (index invalidate) clears bits 0x6F and zeroes the line with no writeback.
- R8: Code 0x14 (index writeback-invalidate) writes the line back to {tag[31:12], set, 6'b0} when bits 0x60 are non-zero. It then clears bits 0x6F and zeroes the line.
- R9: Any other code completes as a no-op, with no array change and no writeback.
- R10: `busy` rises the cycle after a command is accepted and stays high until `done`. `done` is a one-cycle pulse that comes 2 cycles after acceptance without a writeback and 6 cycles after acceptance with one. A command presented while `busy` is high is ignored.
- R11: A writeback is 4 consecutive `wbValid` cycles. Beat b carries line bytes 16b to 16b+15, with the lowest-addressed word in bits [31:0], at `wbAddr` = line base + 16b. `done` follows the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Command request, taken when not busy |
| opCode | input | 5 | Operation code |
| opAddr | input | 32 | Effective address |
| xferWe | input | 1 | Software write of the transfer register |
| xferWdata | input | 32 | Value for the software write |
| xferOut | output | 32 | Transfer register contents |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| wbValid | output | 1 | Writeback beat present |
| wbAddr | output | 32 | Byte address of the current beat |
| wbData | output | 128 | Data of the current beat |

## Verification
The assertions assume three things about the inputs. `opValid` and a software write of the transfer register do not both change state that a running command depends on. The transfer register is written only while the unit is idle. The array contents are reached only through this unit's own commands. The bench keeps to these rules. It fills tags and data only with the store commands, drives the transfer register only between commands, and presents a second request during `busy` only to confirm that it is dropped.

// File: rtl/cop_pkg.sv
package cop_pkg;

  localparam logic [4:0] OP_LOAD_TAG   = 5'h10;
  localparam logic [4:0] OP_LOAD_DATA  = 5'h11;
  localparam logic [4:0] OP_STORE_TAG  = 5'h12;
  localparam logic [4:0] OP_STORE_DATA = 5'h13;
  localparam logic [4:0] OP_IDX_WBINV  = 5'h14;
  localparam logic [4:0] OP_IDX_INV    = 5'h16;
  localparam logic [4:0] OP_HIT_WBINV  = 5'h18;
  localparam logic [4:0] OP_HIT_INV    = 5'h1A;
  localparam logic [4:0] OP_HIT_WB     = 5'h1C;

  localparam logic [31:0] CLEAR_MASK = 32'h0000_006F;
  localparam logic [31:0] DIRTY_MASK = 32'h0000_0040;
  localparam logic [31:0] WB_MASK    = 32'h0000_0060;
  localparam int          VALID_BIT  = 5;

  typedef struct packed {
    logic clrFlags;
    logic zeroLine;
    logic clrDirty;
    logic tagWrite;
    logic dataWrite;
    logic xferTag;
    logic xferData;
    logic useIndexWay;
    logic wbFromTag;
  } cop_strobe_t;

endpackage

// File: rtl/cop_datapath.sv
module cop_datapath
  import cop_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BITS = 128
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  opTake,
  input  logic [31:0]           opAddr,
  input  cop_strobe_t           strb,
  input  logic [1:0]            beat,
  input  logic                  xferWe,
  input  logic [31:0]           xferWdata,
  output logic                  hitAny,
  output logic                  needWb,
  output logic                  alignOk,
  output logic [31:0]           xferOut,
  output logic [31:0]           wbAddr,
  output logic [BEAT_BITS-1:0]  wbData
);

  localparam int SET_W     = $clog2(NUM_SETS);
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int TAG_LO    = OFF_W + SET_W;
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int ENTRIES   = NUM_SETS * 2;
  localparam int IDX_W     = SET_W + 1;

  logic [31:0]          tagMem  [ENTRIES];
  logic [LINE_BITS-1:0] lineMem [ENTRIES];
  logic [31:0]          addrReg;
  logic [31:0]          xferReg;

  logic [SET_W-1:0] setIdx;
  logic [1:0]       hitVec;
  logic             wayPick;
  logic [IDX_W-1:0] lineIdx;
  logic [31:0]      selTag;
  logic [LINE_BITS-1:0] selLine;
  logic [3:0]       wordSel;
  logic [31:0]      wbBase;

  assign setIdx = addrReg[TAG_LO-1:OFF_W];

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [31:0] wayTag;
    assign wayTag    = tagMem[{setIdx, w[0]}];
    assign hitVec[w] = wayTag[VALID_BIT] && (wayTag[31:TAG_LO] == addrReg[31:TAG_LO]);
  end

  assign hitAny  = |hitVec;
  assign wayPick = strb.useIndexWay ? addrReg[0] : !hitVec[0];
  assign lineIdx = {setIdx, wayPick};
  assign selTag  = tagMem[lineIdx];
  assign selLine = lineMem[lineIdx];
  assign needWb  = |(selTag & WB_MASK);
  assign wordSel = addrReg[5:2];
  assign alignOk = !addrReg[1];

  assign wbBase  = strb.wbFromTag ? {selTag[31:TAG_LO], setIdx, {OFF_W{1'b0}}}
                                  : {addrReg[31:OFF_W], {OFF_W{1'b0}}};
  assign wbAddr  = wbBase + {26'd0, beat, 4'd0};
  assign wbData  = selLine[{beat, 7'd0} +: BEAT_BITS];
  assign xferOut = xferReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
    end else if (opTake) begin
      addrReg <= opAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tagMem[i]  <= '0;
        lineMem[i] <= '0;
      end
    end else begin
      if (strb.tagWrite) begin
        tagMem[lineIdx] <= xferReg;
      end else if (strb.clrFlags) begin
        tagMem[lineIdx] <= selTag & ~CLEAR_MASK;
      end else if (strb.clrDirty) begin
        tagMem[lineIdx] <= selTag & ~DIRTY_MASK;
      end
      if (strb.zeroLine) begin
        lineMem[lineIdx] <= '0;
      end else if (strb.dataWrite) begin
        lineMem[lineIdx][{wordSel, 5'd0} +: 32] <= xferReg;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      xferReg <= '0;
    end else if (strb.xferTag) begin
      xferReg <= selTag;
    end else if (strb.xferData) begin
      xferReg <= selLine[{wordSel, 5'd0} +: 32];
    end else if (xferWe) begin
      xferReg <= xferWdata;
    end
  end

  // R4
  clear_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrFlags |=> (tagMem[$past(lineIdx)] & CLEAR_MASK) == 32'd0);

  // R6
  dirty_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrDirty |=> tagMem[$past(lineIdx)] == ($past(selTag) & ~DIRTY_MASK));

  // R3
  aligned_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataWrite || strb.xferData) |-> alignOk);

  // R7
  zero_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.zeroLine |=> lineMem[$past(lineIdx)] == '0);

endmodule

// File: rtl/cop_ctrl.sv
module cop_ctrl
  import cop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        opValid,
  input  logic [4:0]  opCode,
  input  logic        hitAny,
  input  logic        needWb,
  input  logic        alignOk,
  output logic        opTake,
  output logic        busy,
  output logic        done,
  output logic        wbValid,
  output logic [1:0]  beat,
  output cop_strobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_WBACK, ST_FIN} state_t;

  state_t     state;
  logic [4:0] codeReg;
  logic       isHitOp;
  logic       wantWb;
  logic       actNow;

  assign opTake  = opValid && (state == ST_IDLE);
  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_FIN);
  assign wbValid = (state == ST_WBACK);

  assign isHitOp = (codeReg == OP_HIT_INV) || (codeReg == OP_HIT_WBINV) ||
                   (codeReg == OP_HIT_WB);

  always_comb begin
    wantWb = 1'b0;
    unique case (codeReg)
      OP_HIT_WBINV, OP_HIT_WB: wantWb = hitAny && needWb;
      OP_IDX_WBINV:            wantWb = needWb;
      default:                 wantWb = 1'b0;
    endcase
  end

  assign actNow = ((state == ST_LOOK) && !wantWb) ||
                  ((state == ST_WBACK) && (beat == 2'd3));

  always_comb begin
    strb             = '0;
    strb.useIndexWay = !isHitOp;
    strb.wbFromTag   = (codeReg == OP_IDX_WBINV);
    if (actNow) begin
      unique case (codeReg)
        OP_HIT_INV, OP_HIT_WBINV: begin
          strb.clrFlags = hitAny;
          strb.zeroLine = hitAny;
        end
        OP_HIT_WB:     strb.clrDirty  = hitAny;
        OP_IDX_INV, OP_IDX_WBINV: begin
          strb.clrFlags = 1'b1;
          strb.zeroLine = 1'b1;
        end
        OP_LOAD_TAG:   strb.xferTag   = 1'b1;
        OP_STORE_TAG:  strb.tagWrite  = 1'b1;
        OP_LOAD_DATA:  strb.xferData  = alignOk;
        OP_STORE_DATA: strb.dataWrite = alignOk;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      codeReg <= '0;
      beat    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (opValid) begin
          state   <= ST_LOOK;
          codeReg <= opCode;
        end
        ST_LOOK: begin
          beat  <= '0;
          state <= wantWb ? ST_WBACK : ST_FIN;
        end
        ST_WBACK: begin
          beat <= beat + 2'd1;
          if (beat == 2'd3) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R10
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && !busy) |=> (busy && !done && !wbValid));

  // R11
  wb_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && beat != 2'd3) |=> wbValid);

  // R11
  wb_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && beat == 2'd3) |=> (done && !wbValid));

endmodule

// File: rtl/cache_op_unit.sv
module cache_op_unit
  import cop_pkg::*;
#(
  parameter int NUM_SETS = 64,
  parameter int LINE_BYTES = 64,
  parameter int BEAT_BITS = 128
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic [4:0]           opCode,
  input  logic [31:0]          opAddr,
  input  logic                 xferWe,
  input  logic [31:0]          xferWdata,
  output logic [31:0]          xferOut,
  output logic                 busy,
  output logic                 done,
  output logic                 wbValid,
  output logic [31:0]          wbAddr,
  output logic [BEAT_BITS-1:0] wbData
);

  cop_strobe_t strb;
  logic        opTake;
  logic        hitAny;
  logic        needWb;
  logic        alignOk;
  logic [1:0]  beat;

  cop_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .hitAny(hitAny), .needWb(needWb), .alignOk(alignOk),
    .opTake(opTake), .busy(busy), .done(done), .wbValid(wbValid),
    .beat(beat), .strb(strb)
  );

  cop_datapath #(
    .NUM_SETS(NUM_SETS), .LINE_BYTES(LINE_BYTES), .BEAT_BITS(BEAT_BITS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .opTake(opTake), .opAddr(opAddr), .strb(strb),
    .beat(beat), .xferWe(xferWe), .xferWdata(xferWdata),
    .hitAny(hitAny), .needWb(needWb), .alignOk(alignOk),
    .xferOut(xferOut), .wbAddr(wbAddr), .wbData(wbData)
  );

endmodule

// File: tb/cache_op_unit_test.sv
module cache_op_unit_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         opValid = 1'b0;
  logic [4:0]   opCode = '0;
  logic [31:0]  opAddr = '0;
  logic         xferWe = 1'b0;
  logic [31:0]  xferWdata = '0;
  logic [31:0]  xferOut;
  logic         busy, done, wbValid;
  logic [31:0]  wbAddr;
  logic [127:0] wbData;

  int total = 0;
  int bad = 0;
  int lat;
  int wbCount;
  logic [31:0]  wbA [4];
  logic [127:0] wbD [4];
  logic [31:0]  rd;

  always #2.5 clk = ~clk;

  cache_op_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .opAddr(opAddr),
    .xferWe(xferWe), .xferWdata(xferWdata), .xferOut(xferOut), .busy(busy),
    .done(done), .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input logic [4:0] code, input logic [31:0] addr);
    @(negedge clk);
    opValid = 1'b1; opCode = code; opAddr = addr;
    lat = 0; wbCount = 0;
    do begin
      @(posedge clk); @(negedge clk);
      opValid = 1'b0;
      lat++;
      if (wbValid && wbCount < 4) begin
        wbA[wbCount] = wbAddr; wbD[wbCount] = wbData; wbCount++;
      end
    end while (!done && lat < 40);
  endtask

  task automatic setXfer(input logic [31:0] v);
    @(negedge clk); xferWe = 1'b1; xferWdata = v;
    @(negedge clk); xferWe = 1'b0;
  endtask

  task automatic putTag(input int set, input int way, input logic [31:0] v);
    setXfer(v);
    runOp(5'h12, (set << 6) | way);
  endtask

  task automatic getTag(input int set, input int way, output logic [31:0] v);
    runOp(5'h10, (set << 6) | way);
    v = xferOut;
  endtask

  task automatic putWord(input int set, input int way, input int w, input logic [31:0] v);
    setXfer(v);
    runOp(5'h13, (set << 6) | (w << 2) | way);
  endtask

  task automatic getWord(input int set, input int way, input int w, output logic [31:0] v);
    runOp(5'h11, (set << 6) | (w << 2) | way);
    v = xferOut;
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R10 reset busy", busy, 0);
    chk("R10 reset done", done, 0);
    chk("R11 reset wbValid", wbValid, 0);
    chk("R2 reset xfer", xferOut, 0);
    getTag(5, 1, rd);
    chk("R2 reset tag", rd, 0);
  endtask

  task automatic testIndexSelect();
    putTag(3, 1, 32'hABCDE07F);
    putTag(35, 1, 32'h13579020);
    setXfer(0);
    getTag(3, 1, rd);
    chk("R2 tag roundtrip", rd, 32'hABCDE07F);
    chk("R10 latency load tag", lat, 2);
    getTag(35, 1, rd);
    chk("R1 other set", rd, 32'h13579020);
    getTag(3, 0, rd);
    chk("R1 other way", rd, 0);
  endtask

  task automatic testData();
    putWord(2, 0, 0, 32'h11111111);
    putWord(2, 1, 15, 32'h2222FFFF);
    putWord(2, 0, 6, 32'h66666666);
    getWord(2, 1, 15, rd);
    chk("R3 data way1 word15", rd, 32'h2222FFFF);
    getWord(2, 0, 6, rd);
    chk("R3 data way0 word6", rd, 32'h66666666);
    setXfer(32'h0000DEAD);
    runOp(5'h13, (2 << 6) | 2);
    getWord(2, 0, 0, rd);
    chk("R3 misaligned store ignored", rd, 32'h11111111);
    setXfer(32'h00000077);
    runOp(5'h11, (2 << 6) | 2);
    chk("R3 misaligned load ignored", xferOut, 32'h00000077);
  endtask

  task automatic testHitInv();
    putTag(7, 1, 32'h1234507F);
    putWord(7, 1, 5, 32'hCAFEBABE);
    runOp(5'h1A, 32'h999991C0);
    getTag(7, 1, rd);
    chk("R4 miss tag kept", rd, 32'h1234507F);
    getWord(7, 1, 5, rd);
    chk("R4 miss data kept", rd, 32'hCAFEBABE);
    runOp(5'h1A, 32'h123451C0);
    chk("R4 hit inv latency", lat, 2);
    chk("R4 hit inv no writeback", wbCount, 0);
    getTag(7, 1, rd);
    chk("R4 hit inv tag", rd, 32'h12345010);
    getWord(7, 1, 5, rd);
    chk("R4 hit inv data zero", rd, 0);
    putTag(11, 0, 32'h00042020);
    putTag(11, 1, 32'h00042020);
    runOp(5'h1A, 32'h000422C0);
    getTag(11, 0, rd);
    chk("R4 priority way0 cleared", rd, 32'h00042000);
    getTag(11, 1, rd);
    chk("R4 priority way1 kept", rd, 32'h00042020);
  endtask

  task automatic testHitWbInv();
    logic [127:0] exp;
    putTag(9, 0, 32'h0ABCD060);
    for (int i = 0; i < 16; i++) putWord(9, 0, i, 32'h1000 + i);
    runOp(5'h18, 32'h0ABCD264);
    chk("R10 wb latency", lat, 6);
    chk("R11 beat count", wbCount, 4);
    for (int b = 0; b < 4; b++) begin
      exp = {32'h1000 + 4*b + 3, 32'h1000 + 4*b + 2, 32'h1000 + 4*b + 1, 32'h1000 + 4*b};
      chk("R5 wb addr", wbA[b], 32'h0ABCD240 + 16*b);
      chk("R11 wb data", wbD[b], exp);
    end
    getTag(9, 0, rd);
    chk("R5 tag cleared", rd, 32'h0ABCD000);
    getWord(9, 0, 10, rd);
    chk("R5 data zero", rd, 0);
  endtask

  task automatic testHitWb();
    putTag(10, 1, 32'h00FFF0E0);
    putWord(10, 1, 3, 32'h00003333);
    runOp(5'h1C, 32'h00FFF280);
    chk("R6 beat count", wbCount, 4);
    chk("R6 wb addr0", wbA[0], 32'h00FFF280);
    chk("R6 wb data0", wbD[0], {32'h00003333, 96'd0});
    getTag(10, 1, rd);
    chk("R6 only dirty cleared", rd, 32'h00FFF0A0);
    getWord(10, 1, 3, rd);
    chk("R6 data kept", rd, 32'h00003333);
  endtask

  task automatic testIndexInv();
    putTag(12, 1, 32'h0000F060);
    putWord(12, 1, 0, 32'h00000044);
    runOp(5'h16, (12 << 6) | 1);
    chk("R7 latency", lat, 2);
    chk("R7 no writeback", wbCount, 0);
    getTag(12, 1, rd);
    chk("R7 tag cleared", rd, 32'h0000F000);
    getWord(12, 1, 0, rd);
    chk("R7 data zero", rd, 0);
  endtask

  task automatic testIndexWbInv();
    putTag(13, 0, 32'h55555060);
    putWord(13, 0, 15, 32'h00000099);
    runOp(5'h14, 32'hF0000340);
    chk("R8 beat count", wbCount, 4);
    chk("R8 wb addr3 from tag", wbA[3], 32'h55555370);
    chk("R8 wb data3", wbD[3], {32'h00000099, 96'd0});
    getTag(13, 0, rd);
    chk("R8 tag cleared", rd, 32'h55555000);
    runOp(5'h14, 32'hF0000340);
    chk("R8 clean line no writeback", wbCount, 0);
    chk("R8 clean line latency", lat, 2);
  endtask

  task automatic testNoOp();
    putTag(14, 0, 32'h00001070);
    runOp(5'h05, 32'h00001380);
    chk("R9 latency", lat, 2);
    chk("R9 no writeback", wbCount, 0);
    runOp(5'h1F, 32'h00001380);
    getTag(14, 0, rd);
    chk("R9 tag kept", rd, 32'h00001070);
  endtask

  task automatic testBusyIgnore();
    putTag(15, 0, 32'h00002060);
    setXfer(32'hFFFFF0FF);
    @(negedge clk);
    opValid = 1'b1; opCode = 5'h16; opAddr = 15 << 6;
    @(posedge clk); @(negedge clk);
    chk("R10 busy after accept", busy, 1);
    opCode = 5'h12;
    @(posedge clk); @(negedge clk);
    opValid = 1'b0;
    chk("R10 done pulse", done, 1);
    @(posedge clk); @(negedge clk);
    chk("R10 done single cycle", done, 0);
    chk("R10 idle after done", busy, 0);
    getTag(15, 0, rd);
    chk("R10 request during busy ignored", rd, 32'h00002000);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testIndexSelect();
    testData();
    testHitInv();
    testHitWbInv();
    testHitWb();
    testIndexInv();
    testIndexWbInv();
    testNoOp();
    testBusyIgnore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule